// File: doc/BRIEF.md
# Dual-Edge Read Capture FIFO

This block takes double-data-rate read data from a memory device and moves it into the controller clock domain. The data comes with a strobe that toggles only while a read burst returns. Every sample taken on a rising strobe edge goes into one queue, and every sample taken on a falling strobe edge goes into a second queue. The two queues are written from the strobe side and are read as a pair from the controller side. Each pop therefore gives one rise word and one fall word.

The strobe the block receives has already been delayed, so that its edges fall inside the data eye. A qualifier derived from a loopback signal marks the edges that carry real burst data, and edges without it store nothing. On the write side the pointers are Gray-coded and cross into the controller domain through two-flop synchronizers. The read pointer is shared by both queues, and it crosses back into each strobe-edge domain in the same way. The controller sees a valid pair only when both queues hold data. It consumes the pair with a pop request. A sticky flag reports any qualified edge that found its queue full.

Top module: `ddr_rdcap_fifo`

## Requirements
- R1: A qualified sample taken on a rising edge of `strb_dly` is stored in the rise queue, and one taken on a falling edge is stored in the fall queue. Successive pops present the pairs in arrival order, with the rise sample on `rd_rise` and the fall sample on `rd_fall`.
- R2: Each queue holds up to DEPTH entries (16 by default). Sixteen qualified pairs written with no pops are all kept and are read back in order.
- R3: A qualified edge that finds its queue full stores nothing. That edge sets `overflow`, which is high by the third `clk` rising edge after it and stays high until reset.
- R4: A strobe edge with `wr_qual` low writes nothing to either queue.
- R5: `rd_valid` is high only while both queues hold at least one entry. After the falling-edge write of a pair into empty queues, `rd_valid` rises at the second `clk` rising edge.
- R6: When `pop` is high while `rd_valid` is high at a `clk` rising edge, both queues drop their oldest entry at that edge. When `pop` is high while `rd_valid` is low, it has no effect.
- R7: While `rd_valid` is low, `rd_rise` and `rd_fall` are zero.
- R8: `rst_n` low clears every pointer in both domains and clears `overflow`. Data stored before the reset is never presented afterwards.
- R9: While `rd_valid` is high and no pop is taken, `rd_valid`, `rd_rise` and `rd_fall` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| strb_dly | input | 1 | Delayed read strobe; both edges sample data |
| wr_qual | input | 1 | Loopback-derived write qualifier, sampled at each strobe edge |
| dq | input | W | Read data from the memory |
| pop | input | 1 | Consume the presented pair |
| rd_valid | output | 1 | Both queues non-empty; a pair is presented |
| rd_rise | output | W | Oldest rising-edge sample, zero when not valid |
| rd_fall | output | W | Oldest falling-edge sample, zero when not valid |
| overflow | output | 1 | Sticky: a qualified edge found its queue full |

## Verification
A write reaches the controller side two `clk` rising edges after its strobe edge, and the pair is presented only once the fall half has crossed. A pop acts at the next `clk` rising edge. An overflow shows up two `clk` rising edges after the offending edge. The bench model mirrors these delays with its own two-stage copies of the write counts and of the overflow event, and it updates them at each `clk` rising edge. Strobe edges and pop changes are applied 5 ns after that edge. The outputs are compared 15 ns after it, so each comparison sees the state settled by the most recent edge.

// File: rtl/rcap_pkg.sv
package rcap_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } rcap_edge_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/rcap_sync.sv
module rcap_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  logic [N-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/rcap_wr_side.sv
module rcap_wr_side #(
  parameter int                  W     = 8,
  parameter int                  DEPTH = 16,
  parameter rcap_pkg::rcap_edge_e EDGE = rcap_pkg::EDGE_RISE,
  localparam int                 AW    = $clog2(DEPTH),
  localparam int                 PW    = AW + 1
) (
  input  logic          strb,
  input  logic          rst_n,
  input  logic          qual,
  input  logic [W-1:0]  din,
  input  logic [PW-1:0] rgray_in,
  input  logic [AW-1:0] raddr,
  output logic [PW-1:0] wgray,
  output logic [W-1:0]  rdata,
  output logic          ovf,
  output logic          full,
  output logic          push
);

  logic          wclk;
  logic [PW-1:0] rgray_s;
  logic [PW-1:0] rbin_s;
  logic [PW-1:0] wbin_q;
  logic [PW-1:0] wbin_nxt;
  logic          ovf_evt;
  logic [W-1:0]  mem [DEPTH];

  if (EDGE == rcap_pkg::EDGE_FALL) begin : g_fall_clk
    assign wclk = ~strb;
  end else begin : g_rise_clk
    assign wclk = strb;
  end

  rcap_sync #(.N(PW)) u_rsync (
    .clk   (wclk),
    .rst_n (rst_n),
    .d     (rgray_in),
    .q     (rgray_s)
  );

  assign rbin_s   = PW'(rcap_pkg::gray2bin(32'(rgray_s)));
  assign full     = (wbin_q - rbin_s) == PW'(DEPTH);
  assign push     = qual && !full;
  assign ovf_evt  = qual && full;
  assign wbin_nxt = wbin_q + PW'(1);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push) begin
        wbin_q <= wbin_nxt;
        wgray  <= PW'(rcap_pkg::bin2gray(32'(wbin_nxt)));
      end
      if (ovf_evt) begin
        ovf <= 1'b1;
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (push) begin
      mem[wbin_q[AW-1:0]] <= din;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/ddr_rdcap_fifo.sv
module ddr_rdcap_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strb_dly,
  input  logic         wr_qual,
  input  logic [W-1:0] dq,
  input  logic         pop,
  output logic         rd_valid,
  output logic [W-1:0] rd_rise,
  output logic [W-1:0] rd_fall,
  output logic         overflow
);

  logic [PW-1:0] wgray   [2];
  logic [PW-1:0] wgray_s [2];
  logic [PW-1:0] wbin_s  [2];
  logic [PW-1:0] lvl     [2];
  logic [W-1:0]  rdata   [2];
  logic [1:0]    ovf_q;
  logic [1:0]    full_w;
  logic [1:0]    push_w;
  logic [1:0]    nonempty;

  logic [PW-1:0] rbin_q;
  logic [PW-1:0] rgray_q;
  logic [PW-1:0] rbin_nxt;
  logic          pop_fire;
  logic          ovf_any;
  logic [PW-1:0] lvl_rise;
  logic [PW-1:0] lvl_fall;
  logic          push_rise;
  logic          push_fall;

  for (genvar e = 0; e < 2; e++) begin : g_q
    rcap_wr_side #(
      .W     (W),
      .DEPTH (DEPTH),
      .EDGE  ((e == 0) ? rcap_pkg::EDGE_RISE : rcap_pkg::EDGE_FALL)
    ) u_wr (
      .strb     (strb_dly),
      .rst_n    (rst_n),
      .qual     (wr_qual),
      .din      (dq),
      .rgray_in (rgray_q),
      .raddr    (rbin_q[AW-1:0]),
      .wgray    (wgray[e]),
      .rdata    (rdata[e]),
      .ovf      (ovf_q[e]),
      .full     (full_w[e]),
      .push     (push_w[e])
    );

    rcap_sync #(.N(PW)) u_wsync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (wgray[e]),
      .q     (wgray_s[e])
    );

    assign wbin_s[e]   = PW'(rcap_pkg::gray2bin(32'(wgray_s[e])));
    assign lvl[e]      = wbin_s[e] - rbin_q;
    assign nonempty[e] = lvl[e] != '0;
  end

  assign lvl_rise  = lvl[0];
  assign lvl_fall  = lvl[1];
  assign push_rise = push_w[0];
  assign push_fall = push_w[1];

  assign rd_valid = &nonempty;
  assign pop_fire = pop && rd_valid;
  assign rbin_nxt = rbin_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop_fire) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= PW'(rcap_pkg::bin2gray(32'(rbin_nxt)));
    end
  end

  assign rd_rise = rd_valid ? rdata[0] : '0;
  assign rd_fall = rd_valid ? rdata[1] : '0;

  assign ovf_any = |ovf_q;

  rcap_sync #(.N(1)) u_osync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ovf_any),
    .q     (overflow)
  );

endmodule

// File: rtl/rcap_chk.sv
module rcap_chk #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pop,
  input logic          rd_valid,
  input logic [W-1:0]  rd_rise,
  input logic [W-1:0]  rd_fall,
  input logic          overflow,
  input logic          pop_fire,
  input logic [PW-1:0] rbin_q,
  input logic [PW-1:0] lvl_rise,
  input logic [PW-1:0] lvl_fall
);

  p_pair_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> rbin_q == PW'($past(rbin_q) + PW'(1)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_fire |=> $stable(rbin_q));

  p_hold_until_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !pop) |=> (rd_valid && $stable(rd_rise) && $stable(rd_fall)));

  p_sticky_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_rise == '0 && rd_fall == '0));

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_rise <= PW'(DEPTH)) && (lvl_fall <= PW'(DEPTH)));

  p_valid_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (lvl_rise != '0 && lvl_fall != '0));

endmodule

bind ddr_rdcap_fifo rcap_chk #(.W(W), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pop      (pop),
  .rd_valid (rd_valid),
  .rd_rise  (rd_rise),
  .rd_fall  (rd_fall),
  .overflow (overflow),
  .pop_fire (pop_fire),
  .rbin_q   (rbin_q),
  .lvl_rise (lvl_rise),
  .lvl_fall (lvl_fall)
);

// File: tb/tb_ddr_rdcap_fifo.sv
module tb_ddr_rdcap_fifo;

  localparam int W     = 8;
  localparam int DEPTH = 16;

  logic         clk   = 1'b0;
  logic         rst_n = 1'b0;
  logic         strb  = 1'b0;
  logic         qual  = 1'b0;
  logic         pop   = 1'b0;
  logic [W-1:0] dq    = '0;
  logic         rd_valid;
  logic [W-1:0] rd_rise;
  logic [W-1:0] rd_fall;
  logic         overflow;

  always #10 clk = ~clk;

  ddr_rdcap_fifo #(.W(W), .DEPTH(DEPTH)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb_dly (strb),
    .wr_qual  (qual),
    .dq       (dq),
    .pop      (pop),
    .rd_valid (rd_valid),
    .rd_rise  (rd_rise),
    .rd_fall  (rd_fall),
    .overflow (overflow)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // behavioural reference model
  logic [W-1:0] qr[$];
  logic [W-1:0] qf[$];
  int    wr_r, wr_f, rc;
  int    s1r, s2r, s1f, s2f;
  bit    mval, oraw, o1, o2;
  string tag = "R8";

  task automatic model_clear();
    qr.delete(); qf.delete();
    wr_r = 0; wr_f = 0; rc = 0;
    s1r = 0; s2r = 0; s1f = 0; s2f = 0;
    mval = 0; oraw = 0; o1 = 0; o2 = 0;
  endtask

  task automatic check_eq(input string t, input string what,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic model_write(input bit rise, input logic [W-1:0] d);
    if (rise) begin
      if (wr_r - rc >= DEPTH) oraw = 1;
      else begin qr.push_back(d); wr_r++; end
    end else begin
      if (wr_f - rc >= DEPTH) oraw = 1;
      else begin qf.push_back(d); wr_f++; end
    end
  endtask

  task automatic tick(input bit do_edge, input bit q, input logic [W-1:0] d, input bit p);
    @(posedge clk);
    if (!rst_n) begin
      model_clear();
    end else begin
      if (pop && mval) begin
        void'(qr.pop_front()); void'(qf.pop_front()); rc++;
      end
      s2r = s1r; s1r = wr_r; s2f = s1f; s1f = wr_f;
      o2 = o1; o1 = oraw;
      mval = (s2r - rc > 0) && (s2f - rc > 0);
    end
    #5;
    pop = p;
    if (do_edge) begin
      dq = d; qual = q;
      #1;
      strb = ~strb;
      if (q && rst_n) model_write(strb, d);
      #9;
    end else begin
      #10;
    end
    check_eq(tag, "rd_valid", W'(rd_valid), W'(mval));
    check_eq(tag, "rd_rise", rd_rise, mval ? qr[0] : '0);
    check_eq(tag, "rd_fall", rd_fall, mval ? qf[0] : '0);
    check_eq(tag, "overflow", W'(overflow), W'(o2));
  endtask

  task automatic wpair(input bit q, input logic [W-1:0] a, input logic [W-1:0] b);
    tick(1, q, a, 0);
    tick(1, q, b, 0);
  endtask

  task automatic idle(input int n, input bit p);
    for (int i = 0; i < n; i++) tick(0, 0, '0, p);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #5 rst_n = 0;
    model_clear();
    tag = "R8";
    idle(3, 0);
    @(posedge clk);
    #5 rst_n = 1;
    #10;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_clear();
    // R8: outputs cleared while held in reset from time zero
    tag = "R8";
    idle(3, 0);
    @(posedge clk);
    #5 rst_n = 1;
    #10;

    // R5: one pair into empty queues, valid after two clk edges
    tag = "R5";
    wpair(1, 8'h11, 8'h22);
    idle(3, 0);
    // R9: pair held while not popped
    tag = "R9";
    idle(3, 0);
    tag = "R6";
    idle(2, 1);
    idle(1, 0);

    // R1: several pairs in order, rise and fall routed apart
    tag = "R1";
    for (int i = 0; i < 4; i++) wpair(1, W'(8'h30 + i), W'(8'h60 + i));
    idle(3, 0);
    idle(6, 1);
    idle(1, 0);

    // R4: unqualified edges ignored
    tag = "R4";
    wpair(1, 8'hA1, 8'hB1);
    wpair(0, 8'hEE, 8'hFF);
    wpair(1, 8'hA2, 8'hB2);
    idle(3, 0);
    idle(4, 1);
    idle(1, 0);

    // R6: pops on empty ignored, then interleaved pops and writes
    tag = "R6";
    idle(3, 1);
    wpair(1, 8'hC1, 8'hD1);
    tick(1, 1, 8'hC2, 1);
    tick(1, 1, 8'hD2, 1);
    idle(5, 1);
    // R7: data zero while not valid
    tag = "R7";
    idle(3, 0);

    // R8: stale data not presented after reset
    tag = "R8";
    wpair(1, 8'h51, 8'h52);
    wpair(1, 8'h53, 8'h54);
    idle(4, 0);
    do_reset();
    tag = "R8";
    idle(2, 0);
    wpair(1, 8'h77, 8'h78);
    idle(3, 0);
    idle(2, 1);
    idle(1, 0);

    // R2: fill to depth, R3: one more sets sticky overflow
    do_reset();
    tag = "R2";
    for (int i = 0; i < DEPTH; i++) wpair(1, W'(8'h80 + i), W'(8'hC0 + i));
    idle(4, 0);
    tag = "R3";
    wpair(1, 8'h0F, 8'hF0);
    idle(4, 0);
    tag = "R2";
    idle(DEPTH + 2, 1);
    tag = "R3";
    idle(3, 0);

    // R8: reset clears overflow
    do_reset();
    tag = "R8";
    idle(3, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule